// File: doc/BRIEF.md
# Processor Privilege Mode and Trap Logic

This block works out which of three operating modes the processor is in from three control bits of its program status word: the master/slave bit, the memory-map enable bit and the mode-altered bit. The three modes are master, master-protected and slave. Each cycle it compares the current mode with two event flags and raises a trap when one of them calls for it. The first flag marks a privileged instruction about to execute. The second is a protection-violation flag that the memory map reports for the current access. The block also says whether a write to the master/slave bit is allowed.

Master-protected mode sits between the other two. It holds when the processor is in master state, mapping is on and the mode-altered bit is set. In that mode, access protection is enforced the same way as for a mapped slave program. Privileged instructions still run freely in master-protected mode. Traps come out as registered one-cycle pulses. Each carries a vector address and a condition-code flag, which together tell the handler which of the two causes raised it.

Top module: `priv_mode_trap`

## Requirements
- R1: `cur_mode` reflects the status bits in the same cycle. It reads 2 (slave) whenever `psw_slave` is 1. It reads 1 (master-protected) when `psw_slave` is 0 and both `psw_map_en` and `psw_mode_alt` are 1. It reads 0 (master) in every other case.
- R2: A cycle with `ins_valid` and `ins_priv` both high in slave mode produces a trap at the next rising edge: `trap_req`=1, `trap_vec`=PRIV_VEC and `trap_cc4`=0.
- R3: A privileged instruction in master or master-protected mode raises no trap of its own.
- R4: A cycle with `acc_valid` and `acc_violate` both high in mapped slave mode or in master-protected mode produces a trap at the next rising edge: `trap_req`=1, `trap_vec`=PROT_VEC (default 'h40) and `trap_cc4`=1.
- R5: A protection violation raises no trap in unmapped slave mode, in unmapped master mode, or in mapped master mode with `psw_mode_alt` at 0.
- R6: When a privileged-instruction fault and a protection fault occur in the same cycle, the trap carries PRIV_VEC with `trap_cc4`=0.
- R7: `ms_wr_permit` follows `ms_wr_req` in the same cycle while the mode is master or master-protected.
- R8: In slave mode, `ms_wr_permit` stays 0 when `ms_wr_req` is high. The request also raises the privileged trap (PRIV_VEC, `trap_cc4`=0) at the next rising edge.
- R9: While the synchronous active-high reset `rst` is sampled high, `trap_req`, `trap_cc4` and `trap_vec` become 0 at that edge, whatever faults are present.
- R10: `trap_req` is high for exactly one cycle per faulting input cycle. When no trap is raised, `trap_vec` and `trap_cc4` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| psw_slave | input | 1 | Status-word master/slave bit (1 = slave) |
| psw_map_en | input | 1 | Status-word memory-map enable |
| psw_mode_alt | input | 1 | Status-word mode-altered bit |
| ins_valid | input | 1 | An instruction is issuing this cycle |
| ins_priv | input | 1 | The issuing instruction is privileged |
| acc_valid | input | 1 | A memory access is presented this cycle |
| acc_violate | input | 1 | The map forbids the current access |
| ms_wr_req | input | 1 | Attempt to write the master/slave bit |
| cur_mode | output | 2 | 0 master, 1 master-protected, 2 slave |
| trap_req | output | 1 | One-cycle trap request pulse |
| trap_vec | output | VEC_W | Trap vector address |
| trap_cc4 | output | 1 | Condition-code flag sent with the trap |
| ms_wr_permit | output | 1 | Write of the master/slave bit is allowed |

## Verification
The bench builds the block with VEC_W=10, PRIV_VEC='h2C4 and PROT_VEC='h040. With these values the privileged vector uses bits above the eighth. A vector truncated to a narrower field, or a mix-up between the two vectors, therefore shows up at the ports. The bench drives every combination of the eight control and event inputs in sequence. This covers each mode against each fault source and the simultaneous-fault case. The back-to-back sequence also puts a faulting cycle directly after a clean one, and a clean cycle directly after a faulting one.

// File: rtl/priv_mode_pkg.sv
package priv_mode_pkg;

   typedef enum logic [1:0] {
      PM_MASTER      = 2'd0,
      PM_MASTER_PROT = 2'd1,
      PM_SLAVE       = 2'd2
   } pmode_e;

   typedef struct packed {
      logic priv;
      logic prot;
   } fault_s;

endpackage

// File: rtl/pm_mode_decode.sv
module pm_mode_decode
   import priv_mode_pkg::*;
(
   input  logic   slave_bit,
   input  logic   map_bit,
   input  logic   alt_bit,
   output pmode_e mode,
   output logic   prot_apply
);

   always_comb begin
      if (slave_bit)
         mode = PM_SLAVE;
      else if (map_bit && alt_bit)
         mode = PM_MASTER_PROT;
      else
         mode = PM_MASTER;
   end

   // Protection codes matter only in mapped slave or master-protected mode.
   always_comb begin
      unique case (mode)
         PM_SLAVE:       prot_apply = map_bit;
         PM_MASTER_PROT: prot_apply = 1'b1;
         default:        prot_apply = 1'b0;
      endcase
   end

endmodule

// File: rtl/pm_fault_detect.sv
module pm_fault_detect
   import priv_mode_pkg::*;
(
   input  pmode_e mode,
   input  logic   prot_apply,
   input  logic   ins_valid,
   input  logic   ins_priv,
   input  logic   acc_valid,
   input  logic   acc_violate,
   input  logic   ms_wr_req,
   output fault_s fault,
   output logic   ms_wr_permit
);

   logic in_slave;
   logic priv_attempt;

   assign in_slave     = (mode == PM_SLAVE);
   assign priv_attempt = (ins_valid && ins_priv) || ms_wr_req;

   always_comb begin
      fault.priv = in_slave && priv_attempt;
      fault.prot = prot_apply && acc_valid && acc_violate;
   end

   assign ms_wr_permit = ms_wr_req && !in_slave;

endmodule

// File: rtl/pm_trap_reg.sv
module pm_trap_reg
   import priv_mode_pkg::*;
#(
   parameter int unsigned VEC_W    = 8,
   parameter int unsigned PRIV_VEC = 'h41,
   parameter int unsigned PROT_VEC = 'h40
) (
   input  logic             clk,
   input  logic             rst,
   input  fault_s           fault,
   output logic             trap_req,
   output logic [VEC_W-1:0] trap_vec,
   output logic             trap_cc4
);

   localparam logic [VEC_W-1:0] PRIV_V = VEC_W'(PRIV_VEC);
   localparam logic [VEC_W-1:0] PROT_V = VEC_W'(PROT_VEC);

   logic [VEC_W-1:0] vec_nxt;
   logic             cc4_nxt;

   // Fixed priority: the privileged cause beats the protection cause.
   always_comb begin
      if (fault.priv) begin
         vec_nxt = PRIV_V;
         cc4_nxt = 1'b0;
      end else if (fault.prot) begin
         vec_nxt = PROT_V;
         cc4_nxt = 1'b1;
      end else begin
         vec_nxt = '0;
         cc4_nxt = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         trap_req <= 1'b0;
         trap_vec <= '0;
         trap_cc4 <= 1'b0;
      end else begin
         trap_req <= fault.priv || fault.prot;
         trap_vec <= vec_nxt;
         trap_cc4 <= cc4_nxt;
      end
   end

endmodule

// File: rtl/priv_mode_trap.sv
module priv_mode_trap
   import priv_mode_pkg::*;
#(
   parameter int unsigned VEC_W    = 8,
   parameter int unsigned PRIV_VEC = 'h41,
   parameter int unsigned PROT_VEC = 'h40
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             psw_slave,
   input  logic             psw_map_en,
   input  logic             psw_mode_alt,
   input  logic             ins_valid,
   input  logic             ins_priv,
   input  logic             acc_valid,
   input  logic             acc_violate,
   input  logic             ms_wr_req,
   output logic [1:0]       cur_mode,
   output logic             trap_req,
   output logic [VEC_W-1:0] trap_vec,
   output logic             trap_cc4,
   output logic             ms_wr_permit
);

   localparam longint unsigned VEC_SPAN = longint'(1) << VEC_W;

   generate
      if (VEC_W < 1 || VEC_W > 32) begin : g_bad_width
         $error("priv_mode_trap: VEC_W must be 1..32");
      end
      if (PRIV_VEC >= VEC_SPAN || PROT_VEC >= VEC_SPAN) begin : g_bad_range
         $error("priv_mode_trap: a trap vector does not fit in VEC_W bits");
      end
      if (PRIV_VEC == PROT_VEC) begin : g_bad_alias
         $error("priv_mode_trap: the two trap vectors must differ");
      end
   endgenerate

   pmode_e mode;
   logic   prot_apply;
   fault_s fault;

   pm_mode_decode u_mode (
      .slave_bit  (psw_slave),
      .map_bit    (psw_map_en),
      .alt_bit    (psw_mode_alt),
      .mode       (mode),
      .prot_apply (prot_apply)
   );

   pm_fault_detect u_fault (
      .mode         (mode),
      .prot_apply   (prot_apply),
      .ins_valid    (ins_valid),
      .ins_priv     (ins_priv),
      .acc_valid    (acc_valid),
      .acc_violate  (acc_violate),
      .ms_wr_req    (ms_wr_req),
      .fault        (fault),
      .ms_wr_permit (ms_wr_permit)
   );

   pm_trap_reg #(
      .VEC_W    (VEC_W),
      .PRIV_VEC (PRIV_VEC),
      .PROT_VEC (PROT_VEC)
   ) u_trap (
      .clk      (clk),
      .rst      (rst),
      .fault    (fault),
      .trap_req (trap_req),
      .trap_vec (trap_vec),
      .trap_cc4 (trap_cc4)
   );

   assign cur_mode = mode;

endmodule

// File: rtl/priv_mode_trap_chk.sv
module priv_mode_trap_chk #(
   parameter int unsigned VEC_W    = 8,
   parameter int unsigned PRIV_VEC = 'h41,
   parameter int unsigned PROT_VEC = 'h40
) (
   input logic             clk,
   input logic             rst,
   input logic             psw_slave,
   input logic             psw_map_en,
   input logic             psw_mode_alt,
   input logic             ins_valid,
   input logic             ins_priv,
   input logic             acc_valid,
   input logic             acc_violate,
   input logic             ms_wr_req,
   input logic [1:0]       cur_mode,
   input logic             trap_req,
   input logic [VEC_W-1:0] trap_vec,
   input logic             trap_cc4,
   input logic             ms_wr_permit
);

   logic slave_priv;
   logic prot_case;
   logic prot_hit;

   assign slave_priv = psw_slave && ((ins_valid && ins_priv) || ms_wr_req);
   assign prot_case  = psw_map_en && (psw_slave || psw_mode_alt);
   assign prot_hit   = prot_case && acc_valid && acc_violate;

   assert_slave_mode_R1: assert property (@(posedge clk) disable iff (rst)
      psw_slave |-> cur_mode == 2'd2);

   assert_priv_trap_R2: assert property (@(posedge clk) disable iff (rst)
      (psw_slave && ins_valid && ins_priv) |=>
         (trap_req && trap_vec == VEC_W'(PRIV_VEC) && !trap_cc4));

   assert_no_master_trap_R3: assert property (@(posedge clk) disable iff (rst)
      (!psw_slave && !(acc_valid && acc_violate)) |=> !trap_req);

   assert_prot_trap_R4: assert property (@(posedge clk) disable iff (rst)
      (prot_hit && !slave_priv) |=>
         (trap_req && trap_vec == VEC_W'(PROT_VEC) && trap_cc4));

   assert_unmapped_quiet_R5: assert property (@(posedge clk) disable iff (rst)
      (!psw_map_en && !slave_priv) |=> !trap_req);

   assert_priority_R6: assert property (@(posedge clk) disable iff (rst)
      (prot_hit && slave_priv) |=> (trap_vec == VEC_W'(PRIV_VEC) && !trap_cc4));

   assert_permit_master_R7: assert property (@(posedge clk) disable iff (rst)
      ms_wr_permit |-> (!psw_slave && ms_wr_req));

   assert_slave_write_R8: assert property (@(posedge clk) disable iff (rst)
      (psw_slave && ms_wr_req) |=> (trap_req && !trap_cc4));

   assert_pulse_cause_R10: assert property (@(posedge clk) disable iff (rst)
      trap_req |-> $past(slave_priv || prot_hit));

   assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
      !trap_req |-> (trap_vec == '0 && !trap_cc4));

endmodule

bind priv_mode_trap priv_mode_trap_chk #(
   .VEC_W    (VEC_W),
   .PRIV_VEC (PRIV_VEC),
   .PROT_VEC (PROT_VEC)
) chk_i (
   .clk          (clk),
   .rst          (rst),
   .psw_slave    (psw_slave),
   .psw_map_en   (psw_map_en),
   .psw_mode_alt (psw_mode_alt),
   .ins_valid    (ins_valid),
   .ins_priv     (ins_priv),
   .acc_valid    (acc_valid),
   .acc_violate  (acc_violate),
   .ms_wr_req    (ms_wr_req),
   .cur_mode     (cur_mode),
   .trap_req     (trap_req),
   .trap_vec     (trap_vec),
   .trap_cc4     (trap_cc4),
   .ms_wr_permit (ms_wr_permit)
);

// File: tb/priv_mode_trap_tb_top.sv
module priv_mode_trap_tb_top;

   localparam int unsigned VW  = 10;
   localparam int unsigned PVV = 'h2C4;
   localparam int unsigned RVV = 'h040;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst = 1'b1;
   logic          psw_slave = 0, psw_map_en = 0, psw_mode_alt = 0;
   logic          ins_valid = 0, ins_priv = 0, acc_valid = 0, acc_violate = 0;
   logic          ms_wr_req = 0;
   logic [1:0]    cur_mode;
   logic          trap_req, trap_cc4, ms_wr_permit;
   logic [VW-1:0] trap_vec;

   priv_mode_trap #(.VEC_W(VW), .PRIV_VEC(PVV), .PROT_VEC(RVV)) dut_i (
      .clk(clk), .rst(rst),
      .psw_slave(psw_slave), .psw_map_en(psw_map_en), .psw_mode_alt(psw_mode_alt),
      .ins_valid(ins_valid), .ins_priv(ins_priv),
      .acc_valid(acc_valid), .acc_violate(acc_violate),
      .ms_wr_req(ms_wr_req),
      .cur_mode(cur_mode), .trap_req(trap_req), .trap_vec(trap_vec),
      .trap_cc4(trap_cc4), .ms_wr_permit(ms_wr_permit)
   );

   typedef struct {
      logic          req;
      logic [VW-1:0] vec;
      logic          cc4;
      int            tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errs   = 0;
   bit   done   = 0;
   logic prev_trap = 0;

   // Driver: applies one cycle of inputs, checks the combinational outputs
   // and queues the registered result expected after the next edge.
   task automatic drive(input logic r, s, m, a, iv, ip, av, vi, mw);
      logic pf, pr;
      logic [1:0] m_exp;
      exp_t e;
      @(negedge clk);
      rst = r; psw_slave = s; psw_map_en = m; psw_mode_alt = a;
      ins_valid = iv; ins_priv = ip; acc_valid = av; acc_violate = vi; ms_wr_req = mw;
      pf = s && ((iv && ip) || mw);
      pr = av && vi && m && (s || a);
      e.req = !r && (pf || pr);
      e.vec = !e.req ? '0 : (pf ? VW'(PVV) : VW'(RVV));
      e.cc4 = e.req && !pf;
      if (r)                      e.tag = 9;   // R9 reset clears the trap
      else if (pf && pr)          e.tag = 6;   // R6 priority
      else if (pf && !(iv && ip)) e.tag = 8;   // R8 slave write of mode bit
      else if (pf)                e.tag = 2;   // R2 privileged in slave
      else if (pr)                e.tag = 4;   // R4 protection trap
      else if (prev_trap)         e.tag = 10;  // R10 pulse ends
      else if (!s && iv && ip)    e.tag = 3;   // R3 privileged in master
      else                        e.tag = 5;   // R5 no protection check
      prev_trap = e.req;
      q.push_back(e);
      #1;
      m_exp = s ? 2'd2 : ((m && a) ? 2'd1 : 2'd0);
      checks++;
      if (cur_mode !== m_exp) begin
         errs++;
         $display("FAIL R1 cur_mode actual=%0d expected=%0d", cur_mode, m_exp);
      end
      checks++;
      if (ms_wr_permit !== (mw && !s)) begin
         errs++;
         if (s) $display("FAIL R8 ms_wr_permit actual=%0b expected=%0b", ms_wr_permit, 1'b0);
         else   $display("FAIL R7 ms_wr_permit actual=%0b expected=%0b", ms_wr_permit, mw);
      end
   endtask

   // Monitor: compares the registered outputs mid-high after each edge.
   always begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (trap_req !== e.req || trap_vec !== e.vec || trap_cc4 !== e.cc4) begin
            errs++;
            $display("FAIL R%0d trap actual=%0b/%h/%0b expected=%0b/%h/%0b",
                     e.tag, trap_req, trap_vec, trap_cc4, e.req, e.vec, e.cc4);
         end
      end
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         errs++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errs);
         $finish;
      end
   end

   initial begin
      drive(1, 0, 0, 0, 0, 0, 0, 0, 0);
      drive(1, 1, 1, 0, 1, 1, 1, 1, 1);  // R9 faults under reset
      drive(1, 0, 1, 1, 0, 0, 1, 1, 0);
      for (int k = 0; k < 256; k++) begin
         drive(0, k[7], k[6], k[5], k[4], k[3], k[2], k[1], k[0]);
      end
      drive(0, 1, 1, 0, 1, 1, 0, 0, 0);  // R2
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0);  // R10 pulse drops
      drive(0, 0, 1, 1, 0, 0, 1, 1, 0);  // R4 master-protected
      drive(0, 0, 1, 0, 0, 0, 1, 1, 0);  // R5 mapped master, alt clear
      drive(0, 1, 1, 1, 1, 1, 1, 1, 0);  // R6
      drive(1, 1, 1, 1, 1, 1, 1, 1, 1);  // R9 mid-run reset
      drive(0, 0, 0, 0, 0, 0, 0, 0, 1);  // R7
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
      wait (q.size() == 0);
      @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
   end

endmodule